// File: doc/BRIEF.md
# Multi-Channel PWM Timing Controller with Grouped Skew

This block turns a bank of latched 12-bit brightness codes into per-channel on/off enables for a constant-current LED sink array. One free-running 12-bit frame counter, advanced by a one-cycle oscillator tick taken from a faster system clock, is shared by every channel. Each channel stays on for as many ticks as its code says, and the 4096-tick frame repeats for as long as the blank input is low, with no host action needed.

Leaving blank starts a fixed warm-up: counting and the first turn-on happen on the fifth tick after blank falls. A latch event from the register block darkens every output until the next frame begins, and the counter keeps running through it. An over-temperature flag darkens the outputs at once, and they come back on the first tick after the flag clears. To limit inrush current, the channels are split into four interleaved groups, and each group's rising and falling edges lag the previous group's by a fixed number of system-clock cycles.

Top module: `pwm_skew_ctrl`

## Requirements
- R1: While blank_i is high, en_o is all zero, the frame counter is held at 0 and the warm-up sequence restarts.
- R2: After blank_i falls, every channel with a nonzero code turns on with the fifth tick after the fall, and the frame count starts at that tick.
- R3: A channel whose code is g stays high for exactly g ticks per frame, which is g times the tick spacing in system-clock cycles.
- R4: A code of 0 never turns its channel on. A code of 4095 stays low for one tick per frame.
- R5: While blank_i stays low, the 4096-tick frame repeats and nonzero channels turn on again at each frame start.
- R6: A latch_i pulse darkens en_o from that cycle until the next frame start, and it does not reset the counter, so the next frame starts 4096 ticks after the previous one. The new codes apply from that frame on.
- R7: Channel c belongs to group c mod 4. The rising and falling edges of group k lag those of group 0 by k*STEP_CYC system-clock cycles (default STEP_CYC = 2).
- R8: While ovt_i is high, en_o is zero at once. After ovt_i falls, en_o stays zero until the next tick, and from that tick on the outputs follow the frame again.
- R9: The code for channel c sits in gs_i bits [12c+11:12c].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle oscillator-rate tick |
| blank_i | input | 1 | Blank: outputs off and timing reinitialised |
| latch_i | input | 1 | One-cycle pulse: new codes have been latched |
| ovt_i | input | 1 | Over-temperature flag |
| gs_i | input | 288 | Latched codes, 12 bits per channel |
| en_o | output | 24 | Per-channel enable to the current sinks |

## Verification
The assertions assume that tick_i is a single-cycle pulse, that latch_i never lands on the tick that wraps the counter, and that gs_i changes only while blank_i is high or in the cycle of a latch pulse. The stimulus meets these assumptions. Ticks come every fourth cycle. Codes are loaded only during blank or together with latch_i, and the latch pulse sits in the middle of a frame. Blank intervals are also kept longer than the largest group skew, so the delay lines hold no stale enables when a new warm-up begins.

// File: rtl/pwm_skew_pkg.sv
package pwm_skew_pkg;
  // edge lag of a channel's group in system-clock cycles
  function automatic int unsigned skew_cycles(int unsigned ch, int unsigned n_grp,
                                              int unsigned step);
    return (ch % n_grp) * step;
  endfunction
endpackage

// File: rtl/pwm_frame_seq.sv
module pwm_frame_seq #(
  parameter int GS_W        = 12,
  parameter int START_TICKS = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            blank_i,
  input  logic            latch_i,
  output logic [GS_W-1:0] cnt_o,
  output logic            act_o,
  output logic            hold_o
);
  localparam int PRE_W = (START_TICKS > 1) ? $clog2(START_TICKS) : 1;

  logic             run_q;
  logic [PRE_W-1:0] pre_q;
  logic [GS_W-1:0]  cnt_q;
  logic             hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else if (blank_i) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      if (tick_i) begin
        if (!run_q) begin
          if (pre_q == PRE_W'(START_TICKS - 1)) begin
            run_q  <= 1'b1;
            cnt_q  <= '0;
            hold_q <= 1'b0;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '1) hold_q <= 1'b0;  // frame start releases latch hold
        end
      end
      if (latch_i) hold_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign act_o  = run_q & ~hold_q;
  assign hold_o = hold_q;

  a_r1_blank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> (cnt_q == '0 && !run_q));
  a_r2_start_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(tick_i));
  a_r3_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !blank_i) |=> $stable(cnt_q));
  a_r6_latch_keeps_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !blank_i && !tick_i) |=> $stable(cnt_q));
  a_r5_wrap_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && run_q && tick_i && cnt_q == '1 && !blank_i && !latch_i) |=> !hold_q);
endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp #(
  parameter int N_CH = 24,
  parameter int GS_W = 12
) (
  input  logic                 act_i,
  input  logic [GS_W-1:0]      cnt_i,
  input  logic [N_CH*GS_W-1:0] gs_i,
  output logic [N_CH-1:0]      on_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    // on while the frame count is still below the channel's code
    assign on_o[c] = act_i && (cnt_i < gs_i[c*GS_W +: GS_W]);
  end
endmodule

// File: rtl/pwm_skew_line.sv
module pwm_skew_line #(
  parameter int N_CH  = 24,
  parameter int N_GRP = 4,
  parameter int STEP  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] d_i,
  output logic [N_CH-1:0] q_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int D = pwm_skew_pkg::skew_cycles(c, N_GRP, STEP);
    if (D == 0) begin : g_direct
      assign q_o[c] = d_i[c];
    end else begin : g_delay
      logic [D-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= (sr_q << 1) | D'(d_i[c]);
      end
      assign q_o[c] = sr_q[D-1];
    end
  end
endmodule

// File: rtl/pwm_skew_ctrl.sv
module pwm_skew_ctrl #(
  parameter int N_CH        = 24,
  parameter int GS_W        = 12,
  parameter int N_GRP       = 4,
  parameter int STEP_CYC    = 2,
  parameter int START_TICKS = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 blank_i,
  input  logic                 latch_i,
  input  logic                 ovt_i,
  input  logic [N_CH*GS_W-1:0] gs_i,
  output logic [N_CH-1:0]      en_o
);
  logic [GS_W-1:0] cnt;
  logic            act;
  logic            hold;
  logic [N_CH-1:0] raw_on;
  logic [N_CH-1:0] dly_on;
  logic            ovt_q;
  logic            kill;

  pwm_frame_seq #(.GS_W(GS_W), .START_TICKS(START_TICKS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .blank_i(blank_i),
    .latch_i(latch_i),
    .cnt_o  (cnt),
    .act_o  (act),
    .hold_o (hold)
  );

  pwm_chan_cmp #(.N_CH(N_CH), .GS_W(GS_W)) u_cmp (
    .act_i(act),
    .cnt_i(cnt),
    .gs_i (gs_i),
    .on_o (raw_on)
  );

  pwm_skew_line #(.N_CH(N_CH), .N_GRP(N_GRP), .STEP(STEP_CYC)) u_skew (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_on),
    .q_o   (dly_on)
  );

  // over-temperature release waits for the next oscillator tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ovt_q <= 1'b0;
    else if (ovt_i)  ovt_q <= 1'b1;
    else if (tick_i) ovt_q <= 1'b0;
  end

  // forced-off conditions bypass the skew delay
  assign kill = blank_i | ovt_i | ovt_q | latch_i | hold;
  assign en_o = dly_on & {N_CH{~kill}};

  a_r6_latch_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !tick_i) |=> en_o == '0);
  a_r8_ovt_wait_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovt_i && !tick_i) |=> en_o == '0);

  for (genvar c = 0; c < N_CH; c += N_GRP) begin : g_zero
    a_r4_zero_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gs_i[c*GS_W +: GS_W] == '0) |-> !en_o[c]);
  end
endmodule

// File: tb/pwm_skew_ctrl_tb.sv
module pwm_skew_ctrl_tb;
  localparam int N    = 24;
  localparam int W    = 12;
  localparam int DIV  = 4;
  localparam int STEP = 2;
  localparam int P    = 4096 * DIV;

  logic         clk = 1'b0;
  logic         rst_ni, tick_i, blank_i, latch_i, ovt_i;
  logic [N*W-1:0] gs_i;
  logic [N-1:0] en_o;

  always #5 clk = ~clk;

  pwm_skew_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .blank_i(blank_i),
    .latch_i(latch_i), .ovt_i(ovt_i), .gs_i(gs_i), .en_o(en_o)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0, nticks = 0, mark = 0;
  bit mon = 0, watch = 0;
  int on_samples = 0;
  int t0 = 0;
  int exp_gs[N], len[N], nrise[N], nbad[N], first_rise[N], first_fall[N], rise_tk[N];
  bit prev[N];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // tick generator: one pulse every DIV cycles, changed at the falling edge
  initial begin
    int ph;
    ph = 0;
    tick_i = 1'b0;
    forever begin
      @(negedge clk);
      tick_i = (ph == 0);
      if (ph == 0) nticks++;
      ph = (ph + 1) % DIV;
    end
  end

  // pulse monitor, sampled 1 ns after each rising edge
  initial begin
    for (int c = 0; c < N; c++) prev[c] = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (watch && en_o != '0) on_samples++;
      for (int c = 0; c < N; c++) begin
        if (mon) begin
          if (en_o[c] && !prev[c]) begin
            nrise[c]++;
            len[c] = 1;
            if (first_rise[c] < 0) begin
              first_rise[c] = cyc;
              rise_tk[c] = nticks - mark;
            end
          end else if (en_o[c] && len[c] > 0) begin
            len[c]++;
          end else if (!en_o[c] && prev[c] && len[c] > 0) begin
            if (len[c] != exp_gs[c] * DIV) nbad[c]++;
            if (first_fall[c] < 0) first_fall[c] = cyc;
            len[c] = 0;
          end
        end
        prev[c] = en_o[c];
      end
    end
  end

  task automatic mon_clear();
    for (int c = 0; c < N; c++) begin
      len[c] = 0; nrise[c] = 0; nbad[c] = 0;
      first_rise[c] = -1; first_fall[c] = -1; rise_tk[c] = -1;
    end
  endtask

  task automatic cyc_wait(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  function automatic int pat(input int m, input int c);
    if (m == 1) return 100;
    if (m == 2) return 300;
    case (c)
      0: return 1;
      1: return 4095;
      2: return 0;
      3: return 2048;
      13: return 0;
      default: return (c * 173 + 29) % 4096;
    endcase
  endfunction

  // R9: channel c code in bits [12c+11:12c]
  task automatic set_gs(input int m);
    for (int c = 0; c < N; c++) begin
      exp_gs[c] = pat(m, c);
      gs_i[c*W +: W] = W'(exp_gs[c]);
    end
  endtask

  task automatic t_reset();
    cyc_wait(1);
    chk(en_o == '0, "R1 reset", int'(en_o), 0);
  endtask

  task automatic t_blank();
    set_gs(0);
    on_samples = 0;
    watch = 1;
    cyc_wait(200);
    watch = 0;
    chk(on_samples == 0, "R1 blank", on_samples, 0);
  endtask

  task automatic t_pattern();
    mon_clear();
    mon = 1;
    blank_i = 1'b0;
    mark = nticks;
    cyc_wait(2 * P + 60 * DIV);
    mon = 0;
    chk(rise_tk[0] == 5, "R2 start tick", rise_tk[0], 5);
    for (int c = 0; c < N; c++) begin
      if (exp_gs[c] == 0) begin
        chk(nrise[c] == 0, "R4 zero code", nrise[c], 0);
      end else begin
        chk(nrise[c] >= 2, "R5 repeat", nrise[c], 2);
        chk(nbad[c] == 0 && first_fall[c] > 0, "R3 high time", nbad[c], 0);
      end
    end
    chk(nbad[1] == 0 && nrise[1] >= 2, "R4 full code", nbad[1], 0);
    blank_i = 1'b1;
    cyc_wait(20);
  endtask

  task automatic t_skew();
    set_gs(1);
    cyc_wait(2);
    mon_clear();
    mon = 1;
    blank_i = 1'b0;
    mark = nticks;
    cyc_wait(5 * DIV + 100 * DIV + 40);
    t0 = first_rise[0];
    for (int c = 1; c < 8; c++) begin
      chk(first_rise[c] - first_rise[0] == (c % 4) * STEP, "R7 rise skew",
          first_rise[c] - first_rise[0], (c % 4) * STEP);
      chk(first_fall[c] - first_fall[0] == (c % 4) * STEP, "R7 fall skew",
          first_fall[c] - first_fall[0], (c % 4) * STEP);
    end
  endtask

  task automatic t_latch();
    while (cyc < t0 + P + 50 * DIV) cyc_wait(1);
    set_gs(2);
    latch_i = 1'b1;
    cyc_wait(1);
    latch_i = 1'b0;
    mon_clear();
    on_samples = 0;
    watch = 1;
    while (cyc < t0 + 2 * P - 1) cyc_wait(1);
    watch = 0;
    chk(on_samples == 0, "R6 dark until frame start", on_samples, 0);
    cyc_wait(300 * DIV + 20);
    chk(first_rise[0] == t0 + 2 * P, "R6 counter not reset", first_rise[0], t0 + 2 * P);
    chk(nbad[0] == 0 && first_fall[0] > 0, "R6 new code ch0", nbad[0], 0);
    chk(nbad[7] == 0 && first_fall[7] > 0, "R6 new code ch7", nbad[7], 0);
  endtask

  task automatic t_ovt();
    int dark_bad;
    bit t;
    bit seen;
    mon = 0;
    while (cyc < t0 + 3 * P + 20 * DIV) cyc_wait(1);
    ovt_i = 1'b1;
    #1;
    chk(en_o == '0, "R8 off at once", int'(en_o), 0);
    cyc_wait(40);
    chk(en_o == '0, "R8 stays off", int'(en_o), 0);
    ovt_i = 1'b0;
    dark_bad = 0;
    seen = 0;
    for (int i = 0; i < 2 * DIV && !seen; i++) begin
      @(posedge clk);
      t = tick_i;
      #2;
      if (!t) begin
        if (en_o != '0) dark_bad++;
      end else begin
        seen = 1;
        chk(en_o[0] == 1'b1, "R8 resume on tick", int'(en_o[0]), 1);
      end
    end
    chk(dark_bad == 0 && seen, "R8 wait for tick", dark_bad, 0);
    blank_i = 1'b1;
    cyc_wait(10);
  endtask

  initial begin
    rst_ni = 1'b0; blank_i = 1'b1; latch_i = 1'b0; ovt_i = 1'b0; gs_i = '0;
    for (int c = 0; c < N; c++) exp_gs[c] = 0;
    mon_clear();
    cyc_wait(3);
    rst_ni = 1'b1;
    t_reset();
    t_blank();
    t_pattern();
    t_skew();
    t_latch();
    t_ovt();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog R5 act=%0d exp=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule